// File: doc/BRIEF.md
# Soft-Reset Quiesce and Checkstop Controller

This controller sits beside a simple in-order core and handles two events: a soft-reset request and machine-check errors. When a soft reset is accepted, it lets exactly one further instruction finish or fault. It then blocks the completion of every later instruction and waits for the completed-store queue to go empty. At that point it reports that the core is in a recoverable state. If a machine-check error arrives while it is working toward that state, it marks the soft reset as unrecoverable.

A machine-check error is routed by an enable input. When the enable is 1, the block raises a one-cycle exception request that carries the fixed vector 0x00200. When the enable is 0, the block enters checkstop. Checkstop halts instruction completion, raises the freeze enable for every latch outside the bus-clock domain, and can only be left through the synchronous hard reset.

For a short window after hard reset, soft-reset requests are refused. They are also refused while the test logic reports busy. A refused request is reported on an error pulse and starts nothing. Every output is driven straight from a flip-flop.

Top module: `sqc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle at that edge, and every output reads 0 in the following cycle.
- R2: A soft request that is accepted in idle leaves `blk_complete` at 0 until one `instr_done` is sampled. From the next cycle on, `blk_complete` is 1.
- R3: `recovered` rises only in the cycle after `stq_empty` is sampled high while the block is draining stores. While `stq_empty` is low, the block keeps draining.
- R4: A machine check sampled while the block is quiescing sets `unrecoverable`. The flag stays set until a hard reset or a newly accepted soft request.
- R5: A machine check with `mchk_en`=1 gives `exc_req` high for exactly one cycle, starting the cycle after it is sampled. In that cycle `exc_vec` is 0x00200, and `exc_vec` is 0 at all other times.
- R6: A machine check with `mchk_en`=0 sets `ckstop` and `freeze_en` in the next cycle, which is within two cycles. `blk_complete` is also held at 1 in checkstop.
- R7: Once in checkstop, the block ignores soft requests and further machine checks, with no exception and no refusal pulse. Only `rst` clears checkstop.
- R8: A soft request sampled in idle during the first HRST_CYC cycles after `rst` falls, or while `test_busy` is high, gives a one-cycle `sreset_rej` pulse. No quiesce starts.
- R9: A soft-reset sequence with no machine check never raises `exc_req` or `freeze_en`.
- R10: In idle, a machine check sampled in the same cycle as a soft request takes priority, and the soft request is dropped.
- R11: The recovered state holds while `soft_req` stays high. In the cycle after `soft_req` is sampled low, the block returns to idle and `recovered` and `blk_complete` both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_req | input | 1 | Soft-reset request (level) |
| test_busy | input | 1 | Test logic is not idle |
| mchk_err | input | 1 | Machine-check condition |
| mchk_en | input | 1 | Machine-check enable: 1 selects the exception, 0 selects checkstop |
| instr_done | input | 1 | The next instruction completed or faulted |
| stq_empty | input | 1 | The completed-store queue is empty |
| blk_complete | output | 1 | Block completion of further instructions |
| freeze_en | output | 1 | Freeze latches outside the bus-clock domain |
| exc_req | output | 1 | Machine-check exception request pulse |
| exc_vec | output | VEC_W | Exception vector, valid with `exc_req` |
| recovered | output | 1 | The recoverable state has been reached |
| unrecoverable | output | 1 | A machine check interrupted the quiesce |
| sreset_rej | output | 1 | A soft request was refused |
| ckstop | output | 1 | Checkstop state |

## Verification
Every result is registered once. An input sampled at a rising edge therefore appears on the outputs right after that same edge, and the refusal pulse and the exception pulse last only that one cycle. The bench drives its inputs on the falling edge and compares all outputs at the next falling edge. That moment lies exactly one rising edge after the stimulus, so both single-cycle pulses are caught in their only valid cycle. The table of scenarios is applied back to back, so each expected row describes the state one edge after the row before it.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN_ONE,
    ST_DRAIN_STQ,
    ST_RECOVERED,
    ST_MCHK_EXC,
    ST_CKSTOP
  } sqc_state_e;
endpackage

// File: rtl/sqc_hrst_window.sv
module sqc_hrst_window #(
  parameter int HRST_CYC = 4,
  localparam int CNT_W = $clog2(HRST_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic hrst_busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_W'(HRST_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hrst_busy = (cnt_q != '0);

  // the window must be open on the first edge after a hard reset (R8)
  p_window_open_r8: assert property (@(posedge clk) rst |=> hrst_busy);
endmodule

// File: rtl/sqc_fsm.sv
module sqc_fsm
  import sqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_req,
  input  logic       busy,
  input  logic       mchk_err,
  input  logic       mchk_en,
  input  logic       instr_done,
  input  logic       stq_empty,
  output sqc_state_e state_d,
  output logic       unrec_q,
  output logic       rej_q
);
  sqc_state_e state_q;
  sqc_state_e mchk_dst;
  logic       accept;
  logic       quiescing;

  assign mchk_dst  = mchk_en ? ST_MCHK_EXC : ST_CKSTOP;
  assign accept    = (state_q == ST_IDLE) && !mchk_err && soft_req && !busy;
  assign quiescing = (state_q == ST_DRAIN_ONE) || (state_q == ST_DRAIN_STQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (mchk_err) state_d = mchk_dst;
                    else if (soft_req && !busy) state_d = ST_DRAIN_ONE;
      ST_DRAIN_ONE: if (mchk_err) state_d = mchk_dst;
                    else if (instr_done) state_d = ST_DRAIN_STQ;
      ST_DRAIN_STQ: if (mchk_err) state_d = mchk_dst;
                    else if (stq_empty) state_d = ST_RECOVERED;
      ST_RECOVERED: if (mchk_err) state_d = mchk_dst;
                    else if (!soft_req) state_d = ST_IDLE;
      ST_MCHK_EXC:  state_d = mchk_err ? mchk_dst : ST_IDLE;
      ST_CKSTOP:    state_d = ST_CKSTOP;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      unrec_q <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rej_q   <= (state_q == ST_IDLE) && !mchk_err && soft_req && busy;
      if (quiescing && mchk_err) unrec_q <= 1'b1;
      else if (accept) unrec_q <= 1'b0;
    end
  end

  p_one_instr_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN_ONE && instr_done && !mchk_err) |=> (state_q == ST_DRAIN_STQ));
  p_wait_stq_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN_STQ && !stq_empty && !mchk_err) |=> (state_q == ST_DRAIN_STQ));
  p_to_ckstop_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_CKSTOP && mchk_err && !mchk_en) |=> (state_q == ST_CKSTOP));
  p_ckstop_sticks_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CKSTOP) |=> (state_q == ST_CKSTOP && !rej_q));
  p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && soft_req && busy && !mchk_err) |=> (state_q == ST_IDLE && rej_q));
  p_mchk_first_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && mchk_err) |=> (state_q != ST_DRAIN_ONE));
endmodule

// File: rtl/sqc_outreg.sv
module sqc_outreg
  import sqc_pkg::*;
#(
  parameter int             VEC_W    = 20,
  parameter logic [VEC_W-1:0] MCHK_VEC = VEC_W'(32'h0000_0200)
) (
  input  logic             clk,
  input  logic             rst,
  input  sqc_state_e       state_d,
  output logic             blk_complete,
  output logic             freeze_en,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vec,
  output logic             recovered,
  output logic             ckstop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_complete <= 1'b0;
      freeze_en    <= 1'b0;
      exc_req      <= 1'b0;
      exc_vec      <= '0;
      recovered    <= 1'b0;
      ckstop       <= 1'b0;
    end else begin
      blk_complete <= (state_d == ST_DRAIN_STQ) || (state_d == ST_RECOVERED) ||
                      (state_d == ST_CKSTOP);
      freeze_en    <= (state_d == ST_CKSTOP);
      ckstop       <= (state_d == ST_CKSTOP);
      recovered    <= (state_d == ST_RECOVERED);
      exc_req      <= (state_d == ST_MCHK_EXC);
      exc_vec      <= (state_d == ST_MCHK_EXC) ? MCHK_VEC : '0;
    end
  end

  p_vec_valid_r5: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_vec == MCHK_VEC));
  p_no_freeze_exc_r9: assert property (@(posedge clk) disable iff (rst)
    freeze_en |-> !exc_req);
endmodule

// File: rtl/sqc_ctrl.sv
module sqc_ctrl
  import sqc_pkg::*;
#(
  parameter int               HRST_CYC = 4,
  parameter int               VEC_W    = 20,
  parameter logic [VEC_W-1:0] MCHK_VEC = VEC_W'(32'h0000_0200)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_req,
  input  logic             test_busy,
  input  logic             mchk_err,
  input  logic             mchk_en,
  input  logic             instr_done,
  input  logic             stq_empty,
  output logic             blk_complete,
  output logic             freeze_en,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vec,
  output logic             recovered,
  output logic             unrecoverable,
  output logic             sreset_rej,
  output logic             ckstop
);
  logic       hrst_busy;
  sqc_state_e state_d;

  sqc_hrst_window #(.HRST_CYC(HRST_CYC)) win_i (
    .clk(clk), .rst(rst), .hrst_busy(hrst_busy)
  );

  sqc_fsm fsm_i (
    .clk(clk), .rst(rst), .soft_req(soft_req), .busy(hrst_busy | test_busy),
    .mchk_err(mchk_err), .mchk_en(mchk_en), .instr_done(instr_done),
    .stq_empty(stq_empty), .state_d(state_d), .unrec_q(unrecoverable),
    .rej_q(sreset_rej)
  );

  sqc_outreg #(.VEC_W(VEC_W), .MCHK_VEC(MCHK_VEC)) out_i (
    .clk(clk), .rst(rst), .state_d(state_d), .blk_complete(blk_complete),
    .freeze_en(freeze_en), .exc_req(exc_req), .exc_vec(exc_vec),
    .recovered(recovered), .ckstop(ckstop)
  );

  p_exc_single_r5: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !exc_req);
  p_clear_r1: assert property (@(posedge clk)
    rst |=> (!ckstop && !exc_req && !sreset_rej && !unrecoverable));
endmodule

// File: tb/sqc_ctrl_tb_top.sv
module sqc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HRST_CYC   = 4;
  localparam int VEC_W      = 20;
  localparam logic [VEC_W-1:0] EXP_VEC = 20'h00200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_req = 0, test_busy = 0, mchk_err = 0, mchk_en = 0;
  logic instr_done = 0, stq_empty = 0;
  logic blk_complete, freeze_en, exc_req, recovered, unrecoverable, sreset_rej, ckstop;
  logic [VEC_W-1:0] exc_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqc_ctrl #(.HRST_CYC(HRST_CYC), .VEC_W(VEC_W)) dut_i (
    .clk(clk), .rst(rst), .soft_req(soft_req), .test_busy(test_busy),
    .mchk_err(mchk_err), .mchk_en(mchk_en), .instr_done(instr_done),
    .stq_empty(stq_empty), .blk_complete(blk_complete), .freeze_en(freeze_en),
    .exc_req(exc_req), .exc_vec(exc_vec), .recovered(recovered),
    .unrecoverable(unrecoverable), .sreset_rej(sreset_rej), .ckstop(ckstop)
  );

  // row: inputs {soft,tbusy,mchk,en,done,stq} | expected {blk,frz,exc,rec,unrec,rej,ck}
  localparam int NROW = 21;
  localparam logic [12:0] TBL [NROW] = '{
    13'b100000_0000000, // 0  R2 R9 accept
    13'b000000_0000000, // 1  R2 still waiting
    13'b000010_1000000, // 2  R2 one instruction done
    13'b000000_1000000, // 3  R3 queue not empty
    13'b100001_1001000, // 4  R3 drained
    13'b100000_1001000, // 5  R11 hold
    13'b000000_0000000, // 6  R11 release
    13'b001100_0010000, // 7  R5 exception
    13'b000000_0000000, // 8  R5 pulse ends
    13'b101100_0010000, // 9  R10 priority
    13'b000000_0000000, // 10 R10
    13'b110000_0000010, // 11 R8 test busy refusal
    13'b000000_0000000, // 12 R8 no quiesce
    13'b100000_0000000, // 13 R4 accept
    13'b001100_0010100, // 14 R4 mchk during quiesce
    13'b000000_0000100, // 15 R4 sticky
    13'b100000_0000000, // 16 R4 cleared by new accept
    13'b000010_1000000, // 17 R2
    13'b001000_1100101, // 18 R6 checkstop
    13'b100000_1100101, // 19 R7 soft ignored
    13'b001100_1100101  // 20 R7 mchk ignored
  };

  function automatic string tag_of(int r);
    case (r)
      0, 1, 2, 17: return "R2";
      3, 4:        return "R3";
      5, 6:        return "R11";
      7, 8:        return "R5";
      9, 10:       return "R10";
      11, 12:      return "R8";
      13, 14, 15, 16: return "R4";
      18:          return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic drive(input logic [5:0] iv);
    {soft_req, test_busy, mchk_err, mchk_en, instr_done, stq_empty} = iv;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [6:0] exp_o);
    logic [6:0] act;
    logic [VEC_W-1:0] ev;
    act = {blk_complete, freeze_en, exc_req, recovered, unrecoverable, sreset_rej, ckstop};
    ev = exp_o[4] ? EXP_VEC : '0;
    n_chk++;
    if (act !== exp_o || exc_vec !== ev) begin
      n_bad++;
      $display("FAIL %s: outputs %b vec %h, expected %b vec %h", tag, act, exc_vec, exp_o, ev);
    end
  endtask

  task automatic hard_reset();
    rst = 1'b1;
    drive(6'b000000);
    drive(6'b000000);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    hard_reset();
    check("R1", 7'b0000000);                 // reset state
    drive(6'b100000);                        // inside hard-reset window
    check("R8", 7'b0000010);
    drive(6'b000000);
    check("R8", 7'b0000000);
    repeat (HRST_CYC + 2) drive(6'b000000);

    for (int r = 0; r < NROW; r++) begin
      drive(TBL[r][12:7]);
      check(tag_of(r), TBL[r][6:0]);
    end

    hard_reset();                            // only hard reset leaves checkstop
    check("R7", 7'b0000000);
    check("R1", 7'b0000000);
    repeat (HRST_CYC + 2) drive(6'b000000);
    drive(6'b001000);                        // idle mchk, enable clear
    check("R6", 7'b1100001);
    drive(6'b000000);
    check("R7", 7'b1100001);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule